// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a clocked register of `W` stages (eight by default) that can hold its contents, shift toward either end, or take a full word in parallel. Two select bits choose the mode on each rising clock edge. The parallel data port serves as both input and output. On chip it is modelled as a data-in vector, a data-out vector and a per-bit drive enable, so that a pad ring or a shared internal bus can resolve it. An active-low clear empties the register at once, without waiting for a clock edge.

The parallel port is driven only when both active-low output enables are low and the block is not in load mode. Load mode turns the drivers off whatever the enables say, so that outside data can be captured. Two serial outputs always show the first stage (A) and the last stage (H), and they are never disabled. Wire the last-stage output of one instance to the right-serial input of the next, and the first-stage output of that next instance back to the left-serial input of the first. The chain then shifts as one longer word in both directions.

Top module: `usr_shift_reg`

## Requirements
- R1: While `clr_n` is low, every stage reads 0. This takes effect without a clock edge and overrides every mode, including load.
- R2: With `sel` = 2'b00 (hold), every stage keeps its value across the clock edge.
- R3: With `sel` = 2'b01 (shift right), stage i takes stage i-1 on the rising edge. Stage A (bit 0) takes `ser_right_in`.
- R4: With `sel` = 2'b10 (shift left), stage i takes stage i+1 on the rising edge. Stage H (bit W-1) takes `ser_left_in`.
- R5: With `sel` = 2'b11 (load), every stage takes the matching bit of `port_in` on the rising edge.
- R6: `port_oe` is all ones exactly when `oe_a_n` and `oe_b_n` are both low and `sel` is not 2'b11. Otherwise it is all zeros.
- R7: The output enables have no effect on clearing, holding, shifting or loading.
- R8: `ser_first_out` always equals stage A and `ser_last_out` always equals stage H, whatever the enables or the mode.
- R9: `port_out` always presents the current register contents, with bit 0 = stage A.
- R10: Two instances chained through their serial pins shift as one 2W-bit word in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Mode: 00 hold, 01 shift right, 10 shift left, 11 load |
| oe_a_n | input | 1 | First output enable, active low |
| oe_b_n | input | 1 | Second output enable, active low |
| ser_right_in | input | 1 | Serial data into stage A during shift right |
| ser_left_in | input | 1 | Serial data into stage H during shift left |
| port_in | input | W | Parallel port, inbound side |
| port_out | output | W | Parallel port, outbound side (register contents) |
| port_oe | output | W | Per-bit drive enable for the parallel port |
| ser_first_out | output | 1 | Always-driven copy of stage A |
| ser_last_out | output | 1 | Always-driven copy of stage H |

## Verification
The bench builds two instances at the default `W` = 8 and chains them through the serial pins. One 16-bit reference model then covers single-instance behaviour and the carry of bits across the instance boundary in both shift directions. Random modes, enables and serial bits drive the chain. Directed cases add a clear that lands between edges and is released between edges, loads with the enables high, and long runs in one direction that push every bit off the far end.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_LEFT  = 2'b10,
        MODE_LOAD  = 2'b11
    } usr_mode_e;

    typedef struct packed {
        usr_mode_e mode;
        logic      load;
    } usr_ctrl_t;

    function automatic usr_ctrl_t decode_sel(input logic [1:0] sel);
        usr_ctrl_t c;
        c.mode = usr_mode_e'(sel);
        c.load = (sel == 2'b11);
        return c;
    endfunction

    function automatic logic stage_next(
        input usr_mode_e m,
        input logic      self_q,
        input logic      below,
        input logic      above,
        input logic      par
    );
        logic r;
        case (m)
            MODE_RIGHT: r = below;
            MODE_LEFT:  r = above;
            MODE_LOAD:  r = par;
            default:    r = self_q;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic [1:0] sel,
    output usr_ctrl_t  ctrl
);
    always_comb ctrl = decode_sel(sel);
endmodule

// File: rtl/usr_stage_bank.sv
module usr_stage_bank
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  usr_ctrl_t    ctrl,
    input  logic         ser_right_in,
    input  logic         ser_left_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);
    localparam int EXT = W + 2;

    logic [EXT-1:0] ext;
    logic [W-1:0]   d;

    // ext[0] feeds stage 0 from below, ext[EXT-1] feeds stage W-1 from above
    assign ext = {ser_left_in, q, ser_right_in};

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign d[i] = stage_next(ctrl.mode, q[i], ext[i], ext[i+2], par_in[i]);
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/usr_port_drive.sv
module usr_port_drive
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  usr_ctrl_t    ctrl,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic [W-1:0] q,
    output logic [W-1:0] port_out,
    output logic [W-1:0] port_oe,
    output logic         ser_first_out,
    output logic         ser_last_out
);
    logic drive;

    assign drive         = ~oe_a_n & ~oe_b_n & ~ctrl.load;
    assign port_oe       = {W{drive}};
    assign port_out      = q;
    assign ser_first_out = q[0];
    assign ser_last_out  = q[W-1];
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [1:0]   sel,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic         ser_right_in,
    input  logic         ser_left_in,
    input  logic [W-1:0] port_in,
    output logic [W-1:0] port_out,
    output logic [W-1:0] port_oe,
    output logic         ser_first_out,
    output logic         ser_last_out
);
    usr_ctrl_t    ctrl;
    logic [W-1:0] q;

    usr_mode_decode u_dec (
        .sel  (sel),
        .ctrl (ctrl)
    );

    usr_stage_bank #(.W(W)) u_bank (
        .clk          (clk),
        .clr_n        (clr_n),
        .ctrl         (ctrl),
        .ser_right_in (ser_right_in),
        .ser_left_in  (ser_left_in),
        .par_in       (port_in),
        .q            (q)
    );

    usr_port_drive #(.W(W)) u_drv (
        .ctrl          (ctrl),
        .oe_a_n        (oe_a_n),
        .oe_b_n        (oe_b_n),
        .q             (q),
        .port_out      (port_out),
        .port_oe       (port_oe),
        .ser_first_out (ser_first_out),
        .ser_last_out  (ser_last_out)
    );
endmodule

// File: rtl/usr_shift_reg_chk.sv
module usr_shift_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clr_n,
    input logic [1:0]   sel,
    input logic         oe_a_n,
    input logic         oe_b_n,
    input logic         ser_right_in,
    input logic         ser_left_in,
    input logic [W-1:0] port_in,
    input logic [W-1:0] port_out,
    input logic [W-1:0] port_oe,
    input logic         ser_first_out,
    input logic         ser_last_out
);
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) !clr_n |-> port_out == '0); // R1
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(sel) == 2'b00) |-> $stable(port_out)); // R2
    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(sel) == 2'b01) |->
        port_out == {$past(port_out[W-2:0]), $past(ser_right_in)}); // R3
    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(sel) == 2'b10) |->
        port_out == {$past(ser_left_in), $past(port_out[W-1:1])}); // R4
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && $past(sel) == 2'b11) |-> port_out == $past(port_in)); // R5
    AST_LOAD_UNDRIVEN: assert property (@(posedge clk) sel == 2'b11 |-> port_oe == '0); // R6
    AST_ENABLE_OFF: assert property (@(posedge clk) (oe_a_n || oe_b_n) |-> port_oe == '0); // R6
    AST_OE_UNIFORM: assert property (@(posedge clk) port_oe == '0 || port_oe == '1); // R6
    AST_SERIAL_TAPS: assert property (@(posedge clk)
        ser_first_out == port_out[0] && ser_last_out == port_out[W-1]); // R8
endmodule

bind usr_shift_reg usr_shift_reg_chk #(.W(W)) u_chk (
    .clk           (clk),
    .clr_n         (clr_n),
    .sel           (sel),
    .oe_a_n        (oe_a_n),
    .oe_b_n        (oe_b_n),
    .ser_right_in  (ser_right_in),
    .ser_left_in   (ser_left_in),
    .port_in       (port_in),
    .port_out      (port_out),
    .port_oe       (port_oe),
    .ser_first_out (ser_first_out),
    .ser_last_out  (ser_last_out)
);

// File: tb/tb_usr_shift_reg.sv
module tb_usr_shift_reg;
    localparam int W  = 8;
    localparam int W2 = 2 * W;

    logic         clk = 1'b0;
    logic         clr_n;
    logic [1:0]   sel;
    logic         oe_a_n, oe_b_n;
    logic         sr_in, sl_in;
    logic [W-1:0] pin_lo, pin_hi;
    logic [W-1:0] pout_lo, pout_hi, poe_lo, poe_hi;
    logic         first_lo, last_lo, first_hi, last_hi;

    logic [W2-1:0] model;
    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    // low half of the 16-bit chain
    usr_shift_reg #(.W(W)) dut (
        .clk (clk), .clr_n (clr_n), .sel (sel),
        .oe_a_n (oe_a_n), .oe_b_n (oe_b_n),
        .ser_right_in (sr_in), .ser_left_in (first_hi),
        .port_in (pin_lo), .port_out (pout_lo), .port_oe (poe_lo),
        .ser_first_out (first_lo), .ser_last_out (last_lo)
    );

    // high half, fed by the low half's last stage
    usr_shift_reg #(.W(W)) dut_hi (
        .clk (clk), .clr_n (clr_n), .sel (sel),
        .oe_a_n (oe_a_n), .oe_b_n (oe_b_n),
        .ser_right_in (last_lo), .ser_left_in (sl_in),
        .port_in (pin_hi), .port_out (pout_hi), .port_oe (poe_hi),
        .ser_first_out (first_hi), .ser_last_out (last_hi)
    );

    function automatic logic [W2-1:0] model_next(
        input logic [W2-1:0] cur, input logic [1:0] s,
        input logic sr, input logic sl, input logic [W2-1:0] par);
        case (s)
            2'b01:   return {cur[W2-2:0], sr};
            2'b10:   return {sl, cur[W2-1:1]};
            2'b11:   return par;
            default: return cur;
        endcase
    endfunction

    function automatic logic [W-1:0] exp_oe(input logic a, input logic b, input logic [1:0] s);
        return (!a && !b && s != 2'b11) ? '1 : '0;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R9 R10 data"}, 64'({pout_hi, pout_lo}), 64'(model));
        chk({tag, " R6 oe"}, 64'({poe_hi, poe_lo}),
            64'({exp_oe(oe_a_n, oe_b_n, sel), exp_oe(oe_a_n, oe_b_n, sel)}));
        chk({tag, " R8 taps"}, 64'({first_lo, last_lo, first_hi, last_hi}),
            64'({model[0], model[W-1], model[W], model[W2-1]}));
    endtask

    // drive at negedge, clock, check at next negedge
    task automatic step(input logic [1:0] s, input logic a, input logic b,
                        input logic sr, input logic sl, input logic [W2-1:0] par,
                        input string tag);
        sel = s; oe_a_n = a; oe_b_n = b; sr_in = sr; sl_in = sl;
        {pin_hi, pin_lo} = par;
        #1;
        chk({tag, " R6 oe pre-edge"}, 64'({poe_hi, poe_lo}),
            64'({exp_oe(a, b, s), exp_oe(a, b, s)}));
        @(posedge clk);
        model = model_next(model, s, sr, sl, par);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W2-1:0] word;
        void'($urandom(32'h5eed_1234));
        clr_n = 1'b0; sel = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0;
        sr_in = 1'b0; sl_in = 1'b0; pin_lo = '0; pin_hi = '0;
        model = '0;
        repeat (3) @(negedge clk);
        check_all("reset R1");
        clr_n = 1'b1;

        // R5 load with enables high: R7 load still happens
        step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 16'hA55A, "R5 R7 load disabled");
        step(2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFF, "R2 R7 hold disabled");
        step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, "R2 hold enabled");
        // R3 and R10: push ones in from the right across the boundary
        for (int i = 0; i < W2; i++)
            step(2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, "R3 R10 right fill");
        // R4 and R10: push zeros in from the left while disabled (R7)
        for (int i = 0; i < W2; i++)
            step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, "R4 R7 R10 left drain");
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8001, "R5 load ends");
        step(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, "R3 R10 carry up");
        step(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, "R4 R10 carry down");

        // R1: clear in the middle of a cycle, overriding load mode
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, "R5 load all ones");
        sel = 2'b11;
        #2 clr_n = 1'b0;
        #1 chk("R1 clear without edge", 64'({pout_hi, pout_lo}), 64'h0);
        model = '0;
        @(posedge clk);
        #3 chk("R1 clear beats load", 64'({pout_hi, pout_lo}), 64'h0);
        clr_n = 1'b1;
        @(negedge clk);
        chk("R1 released no edge", 64'({pout_hi, pout_lo}), 64'h0);
        step(2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, "R1 R3 first edge after release");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            word = 16'($urandom);
            step(2'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
                 1'($urandom), 1'($urandom), word, "R2 R3 R4 R5 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule